// File: doc/BRIEF.md
# Boot ROM Byte-Port Sequencer

This block connects a host-side request interface to a narrow, shared 8-bit port that reaches an external boot ROM or a byte-wide external register. The external device sees an 18-bit byte address. Outboard latches capture that address, and the block delivers it over two address cycles. A single data cycle follows, with the device enable active. The same eight lines carry the address and control bits first and the data byte after them. Two side lines carry the upper address bits. The upper side line also works as the strobe that loads the outboard latches.

The host presents a request while the block is idle. A request holds a read/write flag, the byte address, a write byte and a wait count. The block then runs three phases of equal length: the first address cycle, the second address cycle and the data cycle. On a read, the port is sampled on the final clock of the data cycle. The result comes back together with a one-clock completion pulse, which occurs in the clock where the device enable returns high.

Top module: `romport_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress: `req_ready` is 1, `rom_ce_n` is 1, `rom_ad_oe` is 0, `rom_side` is 2'b00 and `done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the completion clock. Requests presented while `req_ready` is 0 are ignored and leave the port contents unchanged.
- R3: In the first address cycle `rom_ad_oe` is 1. `rom_ad_out[7:2]` carries address bits [7:2]. Bit 1 is the active-low output enable (0 for a read) and bit 0 is the active-low write enable (0 for a write). `rom_side[0]` carries address bit 16.
- R4: In the second address cycle `rom_ad_oe` is 1, `rom_ad_out` carries address bits [15:8] and `rom_side[0]` carries address bit 17.
- R5: `rom_side[1]` is the latch strobe. It is 1 only on the final clock of each address cycle and 0 on every other address-cycle clock.
- R6: Each of the three phases lasts W clocks, where W is the `wait_cycles` value captured at acceptance. A value of 0 is treated as 1. Changing `wait_cycles` during a transfer has no effect.
- R7: In the data cycle `rom_ce_n` is 0 and `rom_side` carries address bits [1:0]. On a write, `rom_ad_oe` is 1 and `rom_ad_out` carries the write byte. On a read, `rom_ad_oe` is 0.
- R8: On a read, `rdata` takes the value of `rom_ad_in` from the last clock of the data cycle and holds it until the next read completes. Writes do not change `rdata`.
- R9: `done` is 1 for exactly one clock, in the clock in which `rom_ce_n` has just returned high. `req_ready` is also 1 in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| wait_cycles | input | 4 | Clocks per phase (0 treated as 1) |
| req_ready | output | 1 | Idle, request can be accepted |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read byte |
| rom_ad_out | output | 8 | Shared lines, outgoing value |
| rom_ad_oe | output | 1 | Drive enable for the shared lines |
| rom_ad_in | input | 8 | Shared lines, incoming value |
| rom_side | output | 2 | Side lines: [1] strobe or A1, [0] upper address or A0 |
| rom_ce_n | output | 1 | Active-low device enable |

## Verification
The assertions check the port relationships on every cycle. While idle the port is quiet. Acceptance leads at once into a driven address cycle, and the strobe appears only while the lines are driven. The enable falls only right after a strobe clock. The completion pulse is a single clock and coincides with the enable rising. Address and data contents, phase lengths, the wait count captured at acceptance, the sampling clock for read data and the ignoring of requests while busy can only be shown by the bench's reference model. That model predicts every port value on every clock across several wait counts, address patterns and request overlaps.

// File: rtl/romport_pkg.sv
package romport_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR1 = 2'd1,
    PH_ADDR2 = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;
endpackage

// File: rtl/romport_timer.sv
module romport_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_in,
  input  logic              active,
  output logic              last
);
  logic [WAIT_W-1:0] len_q, len_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              len_en, cnt_en;

  always_comb begin
    len_en = start;
    len_d  = (wait_in == '0) ? WAIT_W'(1) : wait_in;
    last   = active && (cnt_q == len_q - WAIT_W'(1));
    cnt_en = start || active;
    if (start || last) cnt_d = '0;
    else               cnt_d = cnt_q + WAIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= WAIT_W'(1);
      cnt_q <= '0;
    end else begin
      if (len_en) len_q <= len_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/romport_fsm.sv
module romport_fsm
  import romport_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   last,
  output phase_t phase,
  output logic   start,
  output logic   done
);
  phase_t phase_q, phase_d;
  logic   done_q, done_d;

  always_comb begin
    start   = (phase_q == PH_IDLE) && req_valid;
    phase_d = phase_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE:  if (start) phase_d = PH_ADDR1;
      PH_ADDR1: if (last)  phase_d = PH_ADDR2;
      PH_ADDR2: if (last)  phase_d = PH_DATA;
      PH_DATA: begin
        if (last) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase = phase_q;
  assign done  = done_q;
endmodule

// File: rtl/romport_drive.sv
module romport_drive
  import romport_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              last,
  input  phase_t            phase,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rom_ad_in,
  output logic [DATA_W-1:0] rom_ad_out,
  output logic              rom_ad_oe,
  output logic [1:0]        rom_side,
  output logic              rom_ce_n,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_LO = DATA_W;
  localparam int HI_HI = 2 * DATA_W - 1;

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cap_rd;

  assign cap_rd = (phase == PH_DATA) && last && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= rom_ad_in;
  end

  always_comb begin
    rom_ad_out = '0;
    rom_ad_oe  = 1'b0;
    rom_side   = 2'b00;
    rom_ce_n   = 1'b1;
    unique case (phase)
      PH_ADDR1: begin
        rom_ad_oe  = 1'b1;
        rom_ad_out = {addr_q[DATA_W-1:2], wr_q, ~wr_q};
        rom_side   = {last, addr_q[ADDR_W-2]};
      end
      PH_ADDR2: begin
        rom_ad_oe  = 1'b1;
        rom_ad_out = addr_q[HI_HI:HI_LO];
        rom_side   = {last, addr_q[ADDR_W-1]};
      end
      PH_DATA: begin
        rom_ce_n   = 1'b0;
        rom_ad_oe  = wr_q;
        rom_ad_out = wr_q ? wdata_q : '0;
        rom_side   = addr_q[1:0];
      end
      default: ;
    endcase
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/romport_seq.sv
module romport_seq
  import romport_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] rom_ad_out,
  output logic              rom_ad_oe,
  input  logic [DATA_W-1:0] rom_ad_in,
  output logic [1:0]        rom_side,
  output logic              rom_ce_n
);
  phase_t phase;
  logic   start, last, active;

  assign active    = (phase != PH_IDLE);
  assign req_ready = (phase == PH_IDLE);

  romport_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .last(last),
    .phase(phase), .start(start), .done(done)
  );

  romport_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_in(wait_cycles),
    .active(active), .last(last)
  );

  romport_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last), .phase(phase),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rom_ad_in(rom_ad_in), .rom_ad_out(rom_ad_out), .rom_ad_oe(rom_ad_oe),
    .rom_side(rom_side), .rom_ce_n(rom_ce_n), .rdata(rdata)
  );
endmodule

// File: rtl/romport_chk.sv
module romport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       rom_ad_oe,
  input logic [1:0] rom_side,
  input logic       rom_ce_n
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rom_ce_n && !rom_ad_oe && rom_side == 2'b00));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && rom_ad_oe && rom_ce_n));

  assert_strobe_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_side[1] && rom_ce_n) |-> rom_ad_oe);

  assert_data_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> $past(rom_side[1]));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_ce_n) |-> (done && req_ready));

  assert_done_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!rom_ce_n));
endmodule

bind romport_seq romport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .rom_ad_oe(rom_ad_oe), .rom_side(rom_side), .rom_ce_n(rom_ce_n)
);

// File: tb/tb_romport_seq.sv
module tb_romport_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [17:0] req_addr;
  logic [7:0]  req_wdata;
  logic [3:0]  wait_cycles;
  logic        req_ready, done;
  logic [7:0]  rdata, rom_ad_out, rom_ad_in;
  logic        rom_ad_oe, rom_ce_n;
  logic [1:0]  rom_side;

  romport_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wait_cycles(wait_cycles),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .rom_ad_out(rom_ad_out), .rom_ad_oe(rom_ad_oe), .rom_ad_in(rom_ad_in),
    .rom_side(rom_side), .rom_ce_n(rom_ce_n)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic       ready;
    logic       ce_n;
    logic       oe;
    logic [7:0] ad;
    logic [1:0] side;
    logic       done;
    logic [7:0] rd;
    logic [1:0] ph;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  logic [7:0] last_rd = 8'h00;

  function automatic logic [7:0] pat(int c);
    return 8'((c * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic push_req(input bit wr, input logic [17:0] a, input logic [7:0] wd,
                          input logic [3:0] w);
    int len;
    exp_t e;
    len = (w == 0) ? 1 : int'(w);
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < len; k++) begin
        e = '0;
        e.ph = 2'(p + 1);
        e.ready = 1'b0;
        e.ce_n = (p != 2);
        if (p == 0) begin
          e.oe = 1'b1; e.ad = {a[7:2], wr, ~wr}; e.side = {k == len - 1, a[16]};
        end else if (p == 1) begin
          e.oe = 1'b1; e.ad = a[15:8]; e.side = {k == len - 1, a[17]};
        end else begin
          e.oe = wr; e.ad = wd; e.side = a[1:0];
        end
        q.push_back(e);
      end
    end
    if (!wr) last_rd = pat(cyc + 3 * len);
    e = '0;
    e.ready = 1'b1; e.ce_n = 1'b1; e.done = 1'b1; e.rd = last_rd;
    q.push_back(e);
  endtask

  // One clock: compare outputs against model, then present inputs for the edge.
  task automatic step(input bit v, input bit wr, input logic [17:0] a,
                      input logic [7:0] wd, input logic [3:0] w);
    exp_t  e;
    string pt;
    @(negedge clk);
    cyc++;
    rom_ad_in = pat(cyc);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = '0; e.ready = 1'b1; e.ce_n = 1'b1;
    end
    case (e.ph)
      2'd1: pt = "R3,R6";
      2'd2: pt = "R4,R6";
      2'd3: pt = "R7,R6";
      default: pt = "R1";
    endcase
    chk(req_ready === e.ready, (e.ph == 0) ? "R1" : "R2", "req_ready", 8'(req_ready), 8'(e.ready));
    chk(rom_ce_n === e.ce_n, pt, "rom_ce_n", 8'(rom_ce_n), 8'(e.ce_n));
    chk(rom_ad_oe === e.oe, pt, "rom_ad_oe", 8'(rom_ad_oe), 8'(e.oe));
    if (e.oe) chk(rom_ad_out === e.ad, pt, "rom_ad_out", rom_ad_out, e.ad);
    chk(rom_side[0] === e.side[0], pt, "rom_side[0]", 8'(rom_side[0]), 8'(e.side[0]));
    if (e.ph == 2'd3)
      chk(rom_side[1] === e.side[1], "R7", "rom_side[1]", 8'(rom_side[1]), 8'(e.side[1]));
    else
      chk(rom_side[1] === e.side[1], "R5", "strobe", 8'(rom_side[1]), 8'(e.side[1]));
    chk(done === e.done, "R9", "done", 8'(done), 8'(e.done));
    if (e.done) chk(rdata === e.rd, "R8", "rdata", rdata, e.rd);
    req_valid = v; req_write = wr; req_addr = a; req_wdata = wd; wait_cycles = w;
    if (v && e.ready) push_req(wr, a, wd, w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 18'h0, 8'h00, 4'd1);
  endtask

  task automatic xfer(input bit wr, input logic [17:0] a, input logic [7:0] wd,
                      input logic [3:0] w);
    step(1'b1, wr, a, wd, w);
    while (q.size() > 0) step(1'b0, 1'b0, 18'h0, 8'h00, 4'd7);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; wait_cycles = 4'd1; rom_ad_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && rom_ce_n === 1'b1 && rom_ad_oe === 1'b0 &&
        rom_side === 2'b00 && done === 1'b0, "R1", "reset state",
        {3'b0, req_ready, rom_ce_n, rom_ad_oe, rom_side}, 8'b0001_1000);
    rst_n = 1'b1;
    idle(3);
    xfer(1'b0, 18'h2A5C3, 8'h00, 4'd1);   // read, shortest phases
    idle(2);
    xfer(1'b1, 18'h1F0A6, 8'h5A, 4'd3);   // write, R6 three clocks/phase
    idle(1);
    xfer(1'b0, 18'h3FFFF, 8'h00, 4'd15);  // read, longest phases, all-ones address
    xfer(1'b0, 18'h00000, 8'h00, 4'd0);   // R6 zero treated as one
    xfer(1'b1, 18'h2AAAA, 8'hC3, 4'd2);   // write leaves rdata (R8)
    // R2: busy requests ignored; R6: wait count changed mid-transfer
    step(1'b1, 1'b0, 18'h15555, 8'h00, 4'd2);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 18'h3C3C3, 8'hFF, 4'd9);
    while (q.size() > 1) step(1'b0, 1'b0, 18'h0, 8'h00, 4'd5);
    // back-to-back: request presented on the completion clock (R9, R2)
    step(1'b1, 1'b1, 18'h0BEEF, 8'h77, 4'd1);
    while (q.size() > 1) step(1'b0, 1'b0, 18'h0, 8'h00, 4'd1);
    xfer(1'b0, 18'h30F0F, 8'h00, 4'd4);
    idle(4);
    summary();
  end
endmodule